// File: doc/BRIEF.md
# Input Clock Alarm Status Register

This block holds the alarm status of one monitored input clock as an 8-bit read-only register. It has three flags. Two of them, no-activity and frequency hard alarm, follow the level signals of their detectors one clock later. The third, the phase-lock alarm, is set by a one-cycle event pulse and stays set until it is cleared.

The way the phase-lock flag clears depends on a configuration bit. With the bit low, software clears the flag by writing a one to its bit position. With the bit high, writes have no effect on the flag. The flag then clears itself a programmed number of seconds after it was last raised. That number is a 6-bit count times a 2-bit scale, and a one-second tick input measures the time.

A read strobe captures the current status into the read-data register, where it stays until the next strobe.

Top module: `clkmon_alarm_stat`

## Requirements
- R1: Status layout: bit 0 is the phase-lock alarm, bit 1 is the frequency hard alarm, and bit 2 is the no-activity alarm. Bits 7 to 3 always read 0. A 1 in a flag means the alarm is active.
- R2: After reset the status reads 8'h06: no-activity is 1, frequency hard is 1 and phase-lock is 0.
- R3: Bits 2 and 1 take the values of det_noact and det_freq_hard one clock after those inputs change. Bus writes never change these bits.
- R4: A pulse on det_plk_event sets the phase-lock flag on the next clock edge. The flag then holds at 1 until one of the clear conditions in R5 or R6 occurs.
- R5: When ptmo_auto is 0, the only thing that clears the phase-lock flag is a bus write with bus_wdata[0]=1. Writes with bit 0 at 0 and seconds ticks leave it set.
- R6: When ptmo_auto is 1, the phase-lock flag clears on the edge of the N-th sec_tick after it was raised, where N = ptmo_count * ptmo_scale. In this mode bus writes do not clear the flag.
- R7: A new det_plk_event while the flag is already set restarts the timeout, so N further ticks are needed before the flag clears.
- R8: When N is 0, the flag clears on the first sec_tick after it was raised.
- R9: If a set event and a clear condition (a write-one, or the tick that ends the timeout) arrive in the same cycle, the flag stays set.
- R10: A bus_rd strobe loads the status into bus_rdata on that clock edge. bus_rdata holds its value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_rd | input | 1 | Read strobe, loads the status into bus_rdata |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; bit 0 = 1 clears the phase-lock flag when ptmo_auto is 0 |
| bus_rdata | output | 8 | Status value captured by the last read |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| ptmo_auto | input | 1 | 1 = timed self-clear, 0 = write-one-to-clear |
| ptmo_count | input | 6 | Timeout count |
| ptmo_scale | input | 2 | Timeout scale factor |
| det_noact | input | 1 | No-activity detector level |
| det_freq_hard | input | 1 | Frequency hard-alarm detector level |
| det_plk_event | input | 1 | Phase-lock alarm event pulse |

## Verification
The assertions assume that ptmo_auto, ptmo_count and ptmo_scale stay constant while the phase-lock flag is set. They also assume that sec_tick and det_plk_event are single-cycle pulses driven synchronously to clk. The stimulus changes the configuration only while the flag is clear. It drives every pulse for exactly one cycle between falling edges, and puts ticks, events and writes in the same cycle only where R9 calls for that overlap.

// File: rtl/clkmon_alarm_pkg.sv
package clkmon_alarm_pkg;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned CNT_W      = 6;
  localparam int unsigned SCALE_W    = 2;
  localparam int unsigned LIM_W      = CNT_W + SCALE_W;
  localparam int unsigned POS_PLK    = 0;
  localparam int unsigned POS_FREQ   = 1;
  localparam int unsigned POS_NOACT  = 2;
  localparam int unsigned NUM_LEVEL  = 2;

  function automatic logic [LIM_W-1:0] tmo_limit(input logic [CNT_W-1:0] cnt,
                                                 input logic [SCALE_W-1:0] scl);
    return LIM_W'(cnt) * LIM_W'(scl);
  endfunction
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkmon_hold_timer.sv
module clkmon_hold_timer #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W:0]   cnt_inc;
  logic             hit;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{LIM_W{1'b0}}, 1'b1};
    hit     = (cnt_inc >= {1'b0, limit});
    expire  = run && tick && hit;
    cnt_d   = cnt_q;
    if (start)
      cnt_d = '0;
    else if (run && tick)
      cnt_d = hit ? '0 : cnt_inc[LIM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> $stable(cnt_q));

  // R7
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));
endmodule

// File: rtl/clkmon_plk_flag.sv
module clkmon_plk_flag
  import clkmon_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_evt,
  input  logic               wr_one,
  input  logic               auto_mode,
  input  logic               tick,
  input  logic [CNT_W-1:0]   tmo_cnt,
  input  logic [SCALE_W-1:0] tmo_scl,
  output logic               flag
);
  logic             flag_q, flag_d;
  logic             tmo_expire;
  logic             clr_sw, clr_auto;
  logic [LIM_W-1:0] limit;

  assign limit = tmo_limit(tmo_cnt, tmo_scl);

  clkmon_hold_timer #(.LIM_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (set_evt),
    .run    (flag_q && auto_mode),
    .tick   (tick),
    .limit  (limit),
    .expire (tmo_expire)
  );

  always_comb begin
    clr_sw   = !auto_mode && wr_one;
    clr_auto = auto_mode && tmo_expire;
    flag_d   = flag_q;
    if (set_evt)
      flag_d = 1'b1;
    else if (clr_sw || clr_auto)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R4
  plk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R5
  plk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(!auto_mode && wr_one) || $past(auto_mode && tick)));

  // R9
  plk_nofall_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> !$past(set_evt));
endmodule

// File: rtl/clkmon_alarm_stat.sv
module clkmon_alarm_stat
  import clkmon_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [STAT_W-1:0]  bus_wdata,
  output logic [STAT_W-1:0]  bus_rdata,
  input  logic               sec_tick,
  input  logic               ptmo_auto,
  input  logic [CNT_W-1:0]   ptmo_count,
  input  logic [SCALE_W-1:0] ptmo_scale,
  input  logic               det_noact,
  input  logic               det_freq_hard,
  input  logic               det_plk_event
);
  logic                 rst_n_s;
  logic [NUM_LEVEL-1:0] lvl_in, lvl_q;
  logic                 plk_q;
  logic [STAT_W-1:0]    status;
  logic [STAT_W-1:0]    rdata_q, rdata_d;

  clkmon_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign lvl_in = {det_noact, det_freq_hard};

  for (genvar g = 0; g < NUM_LEVEL; g++) begin : g_level
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) lvl_q[g] <= 1'b1;
      else          lvl_q[g] <= lvl_in[g];
    end
  end

  clkmon_plk_flag u_plk (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_evt   (det_plk_event),
    .wr_one    (bus_wr && bus_wdata[POS_PLK]),
    .auto_mode (ptmo_auto),
    .tick      (sec_tick),
    .tmo_cnt   (ptmo_count),
    .tmo_scl   (ptmo_scale),
    .flag      (plk_q)
  );

  always_comb begin
    status            = '0;
    status[POS_PLK]   = plk_q;
    status[POS_FREQ]  = lvl_q[0];
    status[POS_NOACT] = lvl_q[1];
    rdata_d           = bus_rd ? status : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rdata[STAT_W-1:POS_NOACT+1] == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/clkmon_alarm_stat_bench.sv
module clkmon_alarm_stat_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sec_tick = 1'b0, ptmo_auto = 1'b0;
  logic [5:0] ptmo_count = '0;
  logic [1:0] ptmo_scale = '0;
  logic       det_noact = 1'b1, det_freq_hard = 1'b1, det_plk_event = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  logic       finished = 1'b0;

  always #5 clk = ~clk;

  clkmon_alarm_stat u_clkmon_alarm_stat (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .ptmo_auto(ptmo_auto), .ptmo_count(ptmo_count), .ptmo_scale(ptmo_scale),
    .det_noact(det_noact), .det_freq_hard(det_freq_hard),
    .det_plk_event(det_plk_event)
  );

  // monitor
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        failures++;
        $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic rd_expect(input logic [7:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic evt();
    @(negedge clk);
    det_plk_event = 1'b1;
    @(negedge clk);
    det_plk_event = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic cfg(input logic a, input logic [5:0] c, input logic [1:0] s);
    @(negedge clk);
    ptmo_auto = a; ptmo_count = c; ptmo_scale = s;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R1: reset value
    rd_expect(8'h06, "R2 reset value");
    rd_expect(8'h06, "R1 reserved bits zero");

    // R3: follow detectors
    @(negedge clk); det_noact = 1'b0; det_freq_hard = 1'b0;
    rd_expect(8'h00, "R3 both detectors low");
    @(negedge clk); det_noact = 1'b1;
    rd_expect(8'h04, "R3 no-activity bit 2");
    @(negedge clk); det_noact = 1'b0; det_freq_hard = 1'b1;
    rd_expect(8'h02, "R3 freq hard bit 1");
    wr(8'hFF);
    rd_expect(8'h02, "R3 write ignored");
    @(negedge clk); det_freq_hard = 1'b0;

    // R4 R5: sticky flag, write-one clear
    cfg(1'b0, 6'd2, 2'd1);
    evt();
    rd_expect(8'h01, "R4 event sets bit 0");
    repeat (5) @(negedge clk);
    rd_expect(8'h01, "R4 flag sticky");
    ticks(3);
    rd_expect(8'h01, "R5 ticks ignored in write mode");
    wr(8'hFE);
    rd_expect(8'h01, "R5 write with bit0=0 ignored");
    wr(8'h01);
    rd_expect(8'h00, "R5 write-one clears");

    // R9: set and write-one together
    @(negedge clk);
    det_plk_event = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
    @(negedge clk);
    det_plk_event = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd_expect(8'h01, "R9 set wins over write-one");
    wr(8'h01);
    rd_expect(8'h00, "R5 clear after R9 case");

    // R6: timed clear, N = 3*1
    cfg(1'b1, 6'd3, 2'd1);
    evt();
    ticks(2);
    rd_expect(8'h01, "R6 still set after 2 of 3 ticks");
    wr(8'h01);
    rd_expect(8'h01, "R6 write ignored in auto mode");
    ticks(1);
    rd_expect(8'h00, "R6 cleared on 3rd tick");

    // R7: restart
    evt();
    ticks(2);
    evt();
    ticks(2);
    rd_expect(8'h01, "R7 restart keeps flag");
    ticks(1);
    rd_expect(8'h00, "R7 cleared after full restart period");

    // R6: N = 2*3 = 6
    cfg(1'b1, 6'd2, 2'd3);
    evt();
    ticks(5);
    rd_expect(8'h01, "R6 set after 5 of 6 ticks");
    ticks(1);
    rd_expect(8'h00, "R6 cleared on 6th tick");

    // R8: zero product
    cfg(1'b1, 6'd5, 2'd0);
    evt();
    rd_expect(8'h01, "R8 set before tick");
    ticks(1);
    rd_expect(8'h00, "R8 zero limit clears on first tick");

    // R9: event on the expiring tick, N=1
    cfg(1'b1, 6'd1, 2'd1);
    evt();
    @(negedge clk);
    det_plk_event = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    det_plk_event = 1'b0; sec_tick = 1'b0;
    rd_expect(8'h01, "R9 event beats expiring tick");
    ticks(1);
    rd_expect(8'h00, "R9 then clears after full period");

    // R10: hold without strobe
    @(negedge clk); det_noact = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h00) begin
      failures++;
      $display("FAIL R10 hold: actual=%02h expected=%02h", bus_rdata, 8'h00);
    end
    rd_expect(8'h04, "R10 strobe loads new status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule